// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Grouped Sub-Sources

This block collects interrupt requests from peripherals and turns them into two active-low processor lines: a fast line and a normal line. Requests arrive through three banks. Primary requests go straight into a primary pending register. Sub-source requests (three per serial channel plus two converter requests) and external-pin requests each latch into a pending register of their own. Each of these two registers has its own mask. The masked sub-source and external bits are OR-reduced in fixed groups, and each group sets one primary pending bit.

After the primary mask is applied, a per-bit mode register sends every surviving request to either the fast line (mode 1) or the normal line (mode 0). Among the unmasked normal requests, the one with the lowest bit index is reported as a one-hot word and as a bit index. Software uses these to pick a handler, and it clears pending bits by writing ones to them. Request inputs are sampled on every clock. A request stays pending after its input drops, until software clears it.

Top module: `irq_ctl_2lvl`

## Requirements
- R1: After reset all pending registers read 0, the primary mask reads all ones, the sub-source mask reads 0x7FFF, the external mask reads 0x00FFFFF0, the mode register reads 0, and both `fiq_n` and `irq_n` are high.
- R2: A request bit that is high at a clock edge sets its pending bit. The bit stays set until a register write with a 1 in that bit position clears it. Writing 0 leaves the bit unchanged. A request and a clear on the same edge leave the bit set.
- R3: In the sub-source pending register ANDed with the inverse of the sub-source mask, bits 0-2 set primary bit 28, bits 3-5 set primary bit 23, bits 6-8 set primary bit 15, and bits 9-10 set primary bit 31. Bits 11-14 set no primary bit. A grouped bit reaches the primary pending register one clock after the sub-source bit latches.
- R4: In the external pending register ANDed with the inverse of the external mask, bits 4-7 set primary bit 4 and bits 8-23 set primary bit 5. Bits 0-3 set no primary bit.
- R5: The active set is the primary pending register ANDed with the inverse of the primary mask. One clock after the active set changes, `fiq_n` is low exactly when an active bit has mode 1, and `irq_n` is low exactly when an active bit has mode 0.
- R6: The ACT register (address 3) holds a one-hot word with only the lowest-index active bit whose mode is 0. The OFFSET register (address 4) holds that bit's index. Both read 0 when no such bit exists.
- R7: Register addresses: 0 primary pending (write-1-to-clear), 1 mode, 2 primary mask, 3 ACT (read-only), 4 OFFSET (read-only), 5 sub-source pending (write-1-to-clear), 6 sub-source mask, 7 external pending (write-1-to-clear), 8 external mask. Read data for `reg_addr` appears on `reg_rdata` one clock later. Writes to ACT and OFFSET have no effect.
- R8: A masked sub-source or external bit still latches in its own pending register but sets no primary bit. Unmasking it later lets it set its group's primary bit.
- R9: While an unmasked sub-source or external bit stays pending, clearing its group's primary bit has no lasting effect, because the bit is set again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_req | input | 32 | Primary request lines |
| sub_req | input | 15 | Sub-source request lines |
| ext_req | input | 24 | External request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| fiq_n | output | 1 | Active-low fast interrupt |
| irq_n | output | 1 | Active-low normal interrupt |

## Verification
The assertions check the following on every cycle:
- pending bits never drop without a write to their register;
- each output line follows the masked, mode-split active set one clock later;
- the sub-source and external groups reach their primary bits one clock after their masked bits are set;
- the ACT word is one-hot and points only at active normal requests;
- the reset values of the masks and the pending register.

Only the bench scenarios show the following:
- the exact group a given sub-source or external bit lands in, and the bits that land in none;
- lowest-index priority among pairs of requests;
- a request that arrives in the same cycle as its clear still winning;
- a primary bit being set again while its sub-source is still pending.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic [3:0] {
    A_PEND  = 4'd0,
    A_MODE  = 4'd1,
    A_MASK  = 4'd2,
    A_ACT   = 4'd3,
    A_OFFS  = 4'd4,
    A_SPEND = 4'd5,
    A_SMASK = 4'd6,
    A_EPEND = 4'd7,
    A_EMASK = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/irq_pend_reg.sv
// Sticky pending register: set from requests, cleared by write-one.
module irq_pend_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_eff) | set;   // a new request beats a clear
  end
endmodule

// File: rtl/irq_cfg_reg.sv
// Plain read/write configuration register with a reset value.
module irq_cfg_reg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/irq_fold.sv
// OR-reduces masked sub-source and external groups onto primary bits.
module irq_fold #(
  parameter int NUM_PRI  = 32,
  parameter int NUM_UART = 3,
  parameter int SUB_W    = 15,
  parameter int EXT_W    = 24,
  parameter int UART_POS [NUM_UART] = '{28, 23, 15},
  parameter int ADC_POS  = 31,
  parameter int EXTL_POS = 4,
  parameter int EXTH_POS = 5
) (
  input  logic [SUB_W-1:0]   sub_act,
  input  logic [EXT_W-1:0]   ext_act,
  output logic [NUM_PRI-1:0] fold
);
  localparam int ADC_LSB = 3 * NUM_UART;

  logic [NUM_UART-1:0] uart_hit;

  genvar u;
  generate
    for (u = 0; u < NUM_UART; u++) begin : g_uart
      assign uart_hit[u] = |sub_act[3*u +: 3];
    end
  endgenerate

  always_comb begin
    fold = '0;
    for (int k = 0; k < NUM_UART; k++)
      if (uart_hit[k]) fold[UART_POS[k]] = 1'b1;
    if (|sub_act[ADC_LSB +: 2])   fold[ADC_POS]  = 1'b1;
    if (|ext_act[7:4])            fold[EXTL_POS] = 1'b1;
    if (|ext_act[EXT_W-1:8])      fold[EXTH_POS] = 1'b1;
  end
endmodule

// File: rtl/irq_prio.sv
// Lowest-index-wins picker: one-hot result plus index.
module irq_prio #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctl_2lvl.sv
module irq_ctl_2lvl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_PRI  = 32,
  parameter int NUM_UART = 3,
  parameter int SUB_W    = 15,
  parameter int EXT_W    = 24,
  parameter int UART_POS [NUM_UART] = '{28, 23, 15},
  parameter int ADC_POS  = 31,
  parameter int EXTL_POS = 4,
  parameter int EXTH_POS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PRI-1:0] pri_req,
  input  logic [SUB_W-1:0]   sub_req,
  input  logic [EXT_W-1:0]   ext_req,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [NUM_PRI-1:0] reg_wdata,
  output logic [NUM_PRI-1:0] reg_rdata,
  output logic               fiq_n,
  output logic               irq_n
);
  localparam int IW = $clog2(NUM_PRI);
  localparam logic [EXT_W-1:0] EXT_MASK_RST = {{(EXT_W-4){1'b1}}, 4'b0000};

  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr);

  logic we_pend, we_mode, we_mask, we_spend, we_smask, we_epend, we_emask;
  assign we_pend  = reg_we && addr == A_PEND;
  assign we_mode  = reg_we && addr == A_MODE;
  assign we_mask  = reg_we && addr == A_MASK;
  assign we_spend = reg_we && addr == A_SPEND;
  assign we_smask = reg_we && addr == A_SMASK;
  assign we_epend = reg_we && addr == A_EPEND;
  assign we_emask = reg_we && addr == A_EMASK;

  logic [NUM_PRI-1:0] pend_q, mask_q, mode_q, fold, pri_set;
  logic [SUB_W-1:0]   spend_q, smask_q, sub_act;
  logic [EXT_W-1:0]   epend_q, emask_q, ext_act;
  logic [NUM_PRI-1:0] act_all, act_vec;
  logic [IW-1:0]      act_idx;

  // second level: sub-source and external pending + masks
  irq_pend_reg #(.W(SUB_W)) u_spend (
    .clk(clk), .rst(rst), .set(sub_req), .clr_we(we_spend),
    .clr_bits(reg_wdata[SUB_W-1:0]), .q(spend_q));
  irq_cfg_reg #(.W(SUB_W), .RST({SUB_W{1'b1}})) u_smask (
    .clk(clk), .rst(rst), .we(we_smask), .d(reg_wdata[SUB_W-1:0]), .q(smask_q));
  irq_pend_reg #(.W(EXT_W)) u_epend (
    .clk(clk), .rst(rst), .set(ext_req), .clr_we(we_epend),
    .clr_bits(reg_wdata[EXT_W-1:0]), .q(epend_q));
  irq_cfg_reg #(.W(EXT_W), .RST(EXT_MASK_RST)) u_emask (
    .clk(clk), .rst(rst), .we(we_emask), .d(reg_wdata[EXT_W-1:0]), .q(emask_q));

  assign sub_act = spend_q & ~smask_q;
  assign ext_act = epend_q & ~emask_q;

  irq_fold #(
    .NUM_PRI(NUM_PRI), .NUM_UART(NUM_UART), .SUB_W(SUB_W), .EXT_W(EXT_W),
    .UART_POS(UART_POS), .ADC_POS(ADC_POS), .EXTL_POS(EXTL_POS), .EXTH_POS(EXTH_POS)
  ) u_fold (.sub_act(sub_act), .ext_act(ext_act), .fold(fold));

  // first level: primary pending, mask, mode
  assign pri_set = pri_req | fold;

  irq_pend_reg #(.W(NUM_PRI)) u_pend (
    .clk(clk), .rst(rst), .set(pri_set), .clr_we(we_pend),
    .clr_bits(reg_wdata), .q(pend_q));
  irq_cfg_reg #(.W(NUM_PRI), .RST({NUM_PRI{1'b1}})) u_mask (
    .clk(clk), .rst(rst), .we(we_mask), .d(reg_wdata), .q(mask_q));
  irq_cfg_reg #(.W(NUM_PRI), .RST('0)) u_mode (
    .clk(clk), .rst(rst), .we(we_mode), .d(reg_wdata), .q(mode_q));

  assign act_all = pend_q & ~mask_q;

  irq_prio #(.W(NUM_PRI)) u_prio (
    .vec(act_all & ~mode_q), .onehot(act_vec), .idx(act_idx));

  // registered outputs
  logic fiq_n_q, irq_n_q;
  logic [NUM_PRI-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    case (addr)
      A_PEND:  rdata_d = pend_q;
      A_MODE:  rdata_d = mode_q;
      A_MASK:  rdata_d = mask_q;
      A_ACT:   rdata_d = act_vec;
      A_OFFS:  rdata_d = NUM_PRI'(act_idx);
      A_SPEND: rdata_d = NUM_PRI'(spend_q);
      A_SMASK: rdata_d = NUM_PRI'(smask_q);
      A_EPEND: rdata_d = NUM_PRI'(epend_q);
      A_EMASK: rdata_d = NUM_PRI'(emask_q);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_n_q <= 1'b1;
      irq_n_q <= 1'b1;
      rdata_q <= '0;
    end else begin
      fiq_n_q <= ~|(act_all & mode_q);
      irq_n_q <= ~|(act_all & ~mode_q);
      rdata_q <= rdata_d;
    end
  end

  assign fiq_n     = fiq_n_q;
  assign irq_n     = irq_n_q;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/irq_ctl_2lvl_chk.sv
module irq_ctl_2lvl_chk
  import irq_ctl_pkg::*;
#(
  parameter int NUM_PRI  = 32,
  parameter int NUM_UART = 3,
  parameter int SUB_W    = 15,
  parameter int EXT_W    = 24,
  parameter int UART_POS [NUM_UART] = '{28, 23, 15},
  parameter int EXTH_POS = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [3:0]         reg_addr,
  input logic [NUM_PRI-1:0] pend_q,
  input logic [NUM_PRI-1:0] mask_q,
  input logic [NUM_PRI-1:0] mode_q,
  input logic [EXT_W-1:0]   emask_q,
  input logic [SUB_W-1:0]   sub_act,
  input logic [EXT_W-1:0]   ext_act,
  input logic [NUM_PRI-1:0] act_vec,
  input logic               fiq_n,
  input logic               irq_n
);
  localparam logic [EXT_W-1:0] EXT_MASK_RST = {{(EXT_W-4){1'b1}}, 4'b0000};

  logic pend_wr;
  assign pend_wr = reg_we && reg_addr == 4'(A_PEND);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && emask_q == EXT_MASK_RST && pend_q == '0 && fiq_n && irq_n)); // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2

  AST_FIQ_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~mask_q & mode_q)) |=> !fiq_n); // R5

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_q & ~mask_q & ~mode_q)) |=> irq_n); // R5

  AST_SUB_FOLD: assert property (@(posedge clk) disable iff (rst)
    (|sub_act[2:0]) |=> pend_q[UART_POS[0]]); // R3

  AST_EXT_FOLD: assert property (@(posedge clk) disable iff (rst)
    (|ext_act[EXT_W-1:8]) |=> pend_q[EXTH_POS]); // R4

  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_vec)); // R6

  AST_ACT_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (act_vec & ~(pend_q & ~mask_q & ~mode_q)) == '0); // R6
endmodule

bind irq_ctl_2lvl irq_ctl_2lvl_chk #(
  .NUM_PRI(NUM_PRI), .NUM_UART(NUM_UART), .SUB_W(SUB_W), .EXT_W(EXT_W),
  .UART_POS(UART_POS), .EXTH_POS(EXTH_POS)
) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .pend_q(pend_q), .mask_q(mask_q), .mode_q(mode_q), .emask_q(emask_q),
  .sub_act(sub_act), .ext_act(ext_act), .act_vec(act_vec),
  .fiq_n(fiq_n), .irq_n(irq_n)
);

// File: tb/irq_ctl_2lvl_tb_top.sv
module irq_ctl_2lvl_tb_top;
  import irq_ctl_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pri_req = '0;
  logic [14:0] sub_req = '0;
  logic [23:0] ext_req = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fiq_n, irq_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_ctl_2lvl dut_i (
    .clk(clk), .rst(rst), .pri_req(pri_req), .sub_req(sub_req), .ext_req(ext_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fiq_n(fiq_n), .irq_n(irq_n));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input reg_addr_e a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input reg_addr_e a, input logic [31:0] exp, input string req);
    reg_addr = 4'(a);
    tick(1);
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  function automatic logic [31:0] sub_group(input int s);
    if (s < 3)  return 32'h1 << 28;
    if (s < 6)  return 32'h1 << 23;
    if (s < 9)  return 32'h1 << 15;
    if (s < 11) return 32'h1 << 31;
    return 32'h0;
  endfunction

  function automatic logic [31:0] ext_group(input int e);
    if (e < 4) return 32'h0;
    if (e < 8) return 32'h1 << 4;
    return 32'h1 << 5;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(fiq_n && irq_n, "R1 outputs", {30'b0, fiq_n, irq_n}, 32'h3);
    rd_chk(A_PEND,  32'h0,        "R1 pend");
    rd_chk(A_MASK,  32'hFFFF_FFFF, "R1 mask");
    rd_chk(A_SMASK, 32'h0000_7FFF, "R1 submask");
    rd_chk(A_EMASK, 32'h00FF_FFF0, "R1 extmask");
    rd_chk(A_MODE,  32'h0,        "R1 mode");

    // R5/R6 normal routing sweep
    wr(A_MASK, 32'h0);
    wr(A_MODE, 32'h0);
    for (int i = 0; i < 32; i++) begin
      pri_req = 32'h1 << i; tick(1); pri_req = '0;
      tick(3);
      check(!irq_n && fiq_n, "R5 normal", {30'b0, fiq_n, irq_n}, 32'h2);
      rd_chk(A_PEND, 32'h1 << i, "R2 latch");
      rd_chk(A_ACT,  32'h1 << i, "R6 act");
      rd_chk(A_OFFS, 32'(i),     "R6 offset");
      wr(A_PEND, 32'h1 << i);
      tick(2);
      check(irq_n, "R2 clear", {31'b0, irq_n}, 32'h1);
    end

    // R5 fast routing sweep
    wr(A_MODE, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      pri_req = 32'h1 << i; tick(1); pri_req = '0;
      tick(3);
      check(!fiq_n && irq_n, "R5 fast", {30'b0, fiq_n, irq_n}, 32'h1);
      rd_chk(A_ACT,  32'h0, "R6 act none");
      rd_chk(A_OFFS, 32'h0, "R6 offset none");
      wr(A_PEND, 32'h1 << i);
    end
    wr(A_MODE, 32'h0);

    // R6 lowest index wins
    for (int i = 0; i < 31; i++) begin
      for (int j = i + 1; j < 32; j += 3) begin
        pri_req = (32'h1 << i) | (32'h1 << j); tick(1); pri_req = '0;
        tick(1);
        rd_chk(A_OFFS, 32'(i), "R6 priority");
        wr(A_PEND, 32'hFFFF_FFFF);
      end
    end

    // R5 masked request latches but does not assert
    wr(A_MASK, 32'hFFFF_FFFF);
    pri_req = 32'h1 << 7; tick(1); pri_req = '0;
    tick(3);
    check(fiq_n && irq_n, "R5 masked", {30'b0, fiq_n, irq_n}, 32'h3);
    rd_chk(A_PEND, 32'h1 << 7, "R2 latch masked");
    wr(A_MASK, ~(32'h1 << 7));
    tick(2);
    check(!irq_n, "R5 unmask", {31'b0, irq_n}, 32'h0);
    wr(A_PEND, 32'h1 << 7);
    wr(A_MASK, 32'h0);

    // R2 write-zero no effect, R7 read-only ACT
    pri_req = 32'h1 << 9; tick(1); pri_req = '0;
    wr(A_PEND, 32'h0);
    rd_chk(A_PEND, 32'h1 << 9, "R2 write zero");
    wr(A_ACT, 32'hFFFF_FFFF);
    wr(A_OFFS, 32'h1F);
    rd_chk(A_ACT,  32'h1 << 9, "R7 act read-only");
    rd_chk(A_OFFS, 32'd9,      "R7 offset read-only");
    wr(A_PEND, 32'h1 << 9);

    // R2 set wins over simultaneous clear
    reg_we = 1'b1; reg_addr = 4'(A_PEND); reg_wdata = 32'h1 << 3; pri_req = 32'h1 << 3;
    tick(1);
    reg_we = 1'b0; pri_req = '0;
    rd_chk(A_PEND, 32'h1 << 3, "R2 set wins");
    wr(A_PEND, 32'h1 << 3);

    // R3 sub-source grouping sweep
    wr(A_SMASK, 32'h0);
    for (int s = 0; s < 15; s++) begin
      sub_req = 15'(1 << s); tick(1); sub_req = '0;
      tick(3);
      rd_chk(A_PEND,  sub_group(s), "R3 sub group");
      rd_chk(A_SPEND, 32'h1 << s,   "R3 sub latch");
      wr(A_SPEND, 32'h1 << s);
      wr(A_PEND, 32'hFFFF_FFFF);
    end

    // R8 sub mask blocks folding; R9 re-set while pending
    wr(A_SMASK, 32'h7FFF);
    sub_req = 15'(1 << 4); tick(1); sub_req = '0;
    tick(3);
    rd_chk(A_PEND,  32'h0,      "R8 sub masked");
    rd_chk(A_SPEND, 32'h1 << 4, "R8 sub latched");
    wr(A_SMASK, 32'h0);
    tick(2);
    rd_chk(A_PEND, 32'h1 << 23, "R8 sub unmask");
    wr(A_PEND, 32'h1 << 23);
    tick(2);
    rd_chk(A_PEND, 32'h1 << 23, "R9 re-set");
    wr(A_SPEND, 32'h7FFF);
    wr(A_PEND, 32'hFFFF_FFFF);
    tick(2);
    rd_chk(A_PEND, 32'h0, "R9 cleared");

    // R4 external grouping sweep
    wr(A_EMASK, 32'h0);
    for (int e = 0; e < 24; e++) begin
      ext_req = 24'(1 << e); tick(1); ext_req = '0;
      tick(3);
      rd_chk(A_PEND,  ext_group(e), "R4 ext group");
      rd_chk(A_EPEND, 32'h1 << e,   "R4 ext latch");
      wr(A_EPEND, 32'h1 << e);
      wr(A_PEND, 32'hFFFF_FFFF);
    end

    // R8 external masked
    wr(A_EMASK, 32'h00FF_FFF0);
    ext_req = 24'(1 << 12); tick(1); ext_req = '0;
    tick(3);
    rd_chk(A_PEND,  32'h0,       "R8 ext masked");
    rd_chk(A_EPEND, 32'h1 << 12, "R8 ext latched");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule